// File: doc/BRIEF.md
# CPU Cycle Arbiter

This block is the top-level cycle controller of a small microcoded processor. At any moment it keeps the machine in exactly one of four states: Halt, Interrupt, Fetch or Exec. It shows that state on a 2-bit status code, and each sequencer decodes the code to decide whether it may run. It also runs a step counter that the active sequencer decodes into steps T1 to T8.

Sequencers give control back over one shared end-of-sequence line, which is active low. The running sequencer pulls the line low in the middle of its final cycle. On the rising edge that ends that cycle, the arbiter does two things. It clears the step counter, so the next period is T1. It also chooses the next state. A pending, enabled interrupt is examined only at the end of an Exec sequence. While halted, the arbiter waits for a console run request. It ignores end-of-sequence and keeps the step count at zero.

Top module: `cyc_arb`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, forces status 2'b00 (Halt) and step 0 whatever the other inputs are. The status encoding, written as {S0,S1}, is Halt=00, Interrupt=01, Fetch=10, Exec=11.
- R2: In Halt without a run request, the block stays in Halt with step 0. A low end-of-sequence has no effect in Halt.
- R3: A run request sampled in Halt moves the block to Fetch (10) with step 0 on that same edge.
- R4: Outside Halt, while end-of-sequence is high, step rises by one per clock edge and wraps from 7 to 0. The state is unchanged.
- R5: End-of-sequence low sampled in Fetch moves the block to Exec (11) and clears step to 0.
- R6: End-of-sequence low sampled in Exec, with the interrupt request and interrupt enable both high, moves the block to Interrupt (01) with step 0.
- R7: End-of-sequence low sampled in Exec, with the interrupt request or enable low, moves the block to Fetch (10) with step 0.
- R8: End-of-sequence low sampled in Interrupt moves the block to Fetch (10) with step 0.
- R9: A run request has no effect in Fetch, Exec or Interrupt.
- R10: Interrupt request and enable have no effect except at the end of Exec. A Fetch end still goes to Exec, and an Interrupt end still goes to Fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run_req | input | 1 | Console run request, one-cycle pulse |
| eos_n | input | 1 | Shared end-of-sequence, active low |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable flag |
| status | output | 2 | Machine state code {S0,S1} |
| step | output | STEP_W (3) | Step count, 0 = T1 ... 7 = T8 |

## Verification
Both the state and the step count are registered outputs, so a wrong next-state choice or a counter slip appears on the ports at the very next clock edge. A wrongly taken branch selects the wrong sequencer at once. A missed clear leaves the new sequence starting at a step other than T1. Comparing every cycle against a bench model therefore localises a fault to the transition that caused it. Directed cases push the counter through its wrap and hit each handoff. Random traffic mixes run pulses, interrupts and resets in every state.

// File: rtl/cyc_arb_pkg.sv
package cyc_arb_pkg;

   // Status code as {S0,S1}; sequencers decode these values directly.
   typedef enum logic [1:0] {
      ST_HALT  = 2'b00,
      ST_INTR  = 2'b01,
      ST_FETCH = 2'b10,
      ST_EXEC  = 2'b11
   } mstate_t;

   // Outcome of one handoff decision.
   typedef struct packed {
      mstate_t nxt;
      logic    clr;
      logic    inc;
   } arb_dec_t;

endpackage

// File: rtl/cyc_arb_next.sv
// Combinational next-state and counter-control decision.
module cyc_arb_next
   import cyc_arb_pkg::*;
#(
   parameter bit IRQ_AT_EXEC_ONLY = 1'b1
) (
   input  mstate_t  cur,
   input  logic     run_req,
   input  logic     eos_n,
   input  logic     irq_req,
   input  logic     irq_en,
   output arb_dec_t dec
);

   logic irq_take;

   // Interrupt qualification: variant chosen at elaboration.
   generate
      if (IRQ_AT_EXEC_ONLY) begin : g_irq_exec
         assign irq_take = irq_req & irq_en & (cur == ST_EXEC);
      end else begin : g_irq_any
         assign irq_take = irq_req & irq_en;
      end
   endgenerate

   always_comb begin
      dec.nxt = cur;
      dec.clr = 1'b0;
      dec.inc = 1'b0;
      unique case (cur)
         ST_HALT: begin
            dec.clr = 1'b1;
            if (run_req) dec.nxt = ST_FETCH;
         end
         ST_FETCH: begin
            if (!eos_n) begin
               dec.nxt = ST_EXEC;
               dec.clr = 1'b1;
            end else begin
               dec.inc = 1'b1;
            end
         end
         ST_EXEC: begin
            if (!eos_n) begin
               dec.nxt = irq_take ? ST_INTR : ST_FETCH;
               dec.clr = 1'b1;
            end else begin
               dec.inc = 1'b1;
            end
         end
         ST_INTR: begin
            if (!eos_n) begin
               dec.nxt = ST_FETCH;
               dec.clr = 1'b1;
            end else begin
               dec.inc = 1'b1;
            end
         end
         default: begin
            dec.nxt = ST_HALT;
            dec.clr = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/cyc_arb_step.sv
// Wrapping step counter with synchronous clear.
module cyc_arb_step #(
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              inc,
   output logic [STEP_W-1:0] cnt
);

   localparam logic [STEP_W-1:0] ONE = {{(STEP_W-1){1'b0}}, 1'b1};

   generate
      if (STEP_W < 1) begin : g_bad_width
         $error("cyc_arb_step: STEP_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (inc)  cnt <= cnt + ONE;
   end

   AST_STEP_INC:   assert property (@(posedge clk) disable iff (rst)
                      (inc && !clr) |=> cnt == $past(cnt) + ONE);           // R4
   AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
                      clr |=> cnt == '0);                                  // R5

endmodule

// File: rtl/cyc_arb.sv
// Top-level cycle arbiter: state register, decision logic, step counter.
module cyc_arb
   import cyc_arb_pkg::*;
#(
   parameter int STEP_W           = 3,
   parameter bit IRQ_AT_EXEC_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run_req,
   input  logic              eos_n,
   input  logic              irq_req,
   input  logic              irq_en,
   output logic [1:0]        status,
   output logic [STEP_W-1:0] step
);

   localparam logic [STEP_W-1:0] ONE = {{(STEP_W-1){1'b0}}, 1'b1};

   generate
      if (STEP_W < 3) begin : g_short_step
         $error("cyc_arb: STEP_W below 3 cannot reach step T8");
      end
   endgenerate

   mstate_t  st_q;
   arb_dec_t dec;

   cyc_arb_next #(
      .IRQ_AT_EXEC_ONLY(IRQ_AT_EXEC_ONLY)
   ) i_next (
      .cur    (st_q),
      .run_req(run_req),
      .eos_n  (eos_n),
      .irq_req(irq_req),
      .irq_en (irq_en),
      .dec    (dec)
   );

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_HALT;
      else     st_q <= dec.nxt;
   end

   cyc_arb_step #(
      .STEP_W(STEP_W)
   ) i_step (
      .clk(clk),
      .rst(rst),
      .clr(dec.clr),
      .inc(dec.inc),
      .cnt(step)
   );

   assign status = st_q;

   AST_RESET_HALT: assert property (@(posedge clk)
                      rst |=> (status == 2'b00 && step == '0));            // R1
   AST_HALT_HOLD:  assert property (@(posedge clk) disable iff (rst)
                      (status == 2'b00 && !run_req) |=> (status == 2'b00 && step == '0)); // R2
   AST_RUN_FETCH:  assert property (@(posedge clk) disable iff (rst)
                      (status == 2'b00 && run_req) |=> (status == 2'b10 && step == '0)); // R3
   AST_COUNT_UP:   assert property (@(posedge clk) disable iff (rst)
                      (status != 2'b00 && eos_n) |=> (status == $past(status) && step == $past(step) + ONE)); // R4
   AST_FETCH_EXEC: assert property (@(posedge clk) disable iff (rst)
                      (status == 2'b10 && !eos_n) |=> (status == 2'b11 && step == '0)); // R5
   AST_EXEC_INTR:  assert property (@(posedge clk) disable iff (rst)
                      (status == 2'b11 && !eos_n && irq_req && irq_en) |=> (status == 2'b01 && step == '0)); // R6
   AST_EXEC_FETCH: assert property (@(posedge clk) disable iff (rst)
                      (status == 2'b11 && !eos_n && !(irq_req && irq_en)) |=> (status == 2'b10 && step == '0)); // R7
   AST_INTR_FETCH: assert property (@(posedge clk) disable iff (rst)
                      (status == 2'b01 && !eos_n) |=> (status == 2'b10 && step == '0)); // R8

endmodule

// File: tb/test_cyc_arb.sv
module test_cyc_arb;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic       rst = 1'b1, run_req = 1'b0, eos_n = 1'b1, irq_req = 1'b0, irq_en = 1'b0;
   logic [1:0] status;
   logic [2:0] step;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [1:0] m_st;
   logic [2:0] m_step;

   cyc_arb i_cyc_arb (
      .clk(clk), .rst(rst), .run_req(run_req), .eos_n(eos_n),
      .irq_req(irq_req), .irq_en(irq_en), .status(status), .step(step)
   );

   // Requirement that governs the transition from the model state under these inputs.
   function automatic string tag_of(input logic r, input logic run, input logic e,
                                    input logic iq, input logic ie);
      if (r) return "R1";
      if (m_st == 2'b00) return run ? "R3" : "R2";
      if (e) return run ? "R9" : "R4";
      if (m_st == 2'b10) return (iq && ie) ? "R10" : "R5";
      if (m_st == 2'b11) return (iq && ie) ? "R6" : "R7";
      return (iq && ie) ? "R10" : "R8";
   endfunction

   task automatic model_step(input logic r, input logic run, input logic e,
                             input logic iq, input logic ie);
      if (r) begin
         m_st = 2'b00; m_step = 3'd0;
      end else if (m_st == 2'b00) begin
         m_step = 3'd0;
         if (run) m_st = 2'b10;
      end else if (e) begin
         m_step = m_step + 3'd1;
      end else begin
         m_step = 3'd0;
         case (m_st)
            2'b10:   m_st = 2'b11;
            2'b11:   m_st = (iq && ie) ? 2'b01 : 2'b10;
            default: m_st = 2'b10;
         endcase
      end
   endtask

   // Called at a falling edge: drive, advance model, check at next falling edge.
   task automatic apply(input logic r, input logic run, input logic e,
                        input logic iq, input logic ie);
      string t;
      t = tag_of(r, run, e, iq, ie);
      rst = r; run_req = run; eos_n = e; irq_req = iq; irq_en = ie;
      model_step(r, run, e, iq, ie);
      @(negedge clk);
      n_tests++;
      if (status !== m_st || step !== m_step) begin
         n_fail++;
         $display("FAIL %s: status=%b step=%0d expected status=%b step=%0d",
                  t, status, step, m_st, m_step);
      end
   endtask

   initial begin
      m_st = 2'b00; m_step = 3'd0;
      void'($urandom(32'd4711));
      @(negedge clk);
      apply(1, 1, 0, 1, 1);                      // R1 reset under busy inputs
      apply(0, 0, 0, 1, 1);                      // R2 eos low ignored in Halt
      apply(0, 0, 1, 0, 0);                      // R2
      apply(0, 1, 1, 0, 0);                      // R3 run -> Fetch
      for (int i = 0; i < 9; i++)
         apply(0, 0, 1, 1, 1);                   // R4 count and wrap
      apply(0, 0, 0, 1, 1);                      // R10 Fetch end -> Exec despite irq
      apply(0, 1, 1, 0, 0);                      // R9 run ignored in Exec
      apply(0, 0, 0, 1, 0);                      // R7 irq disabled -> Fetch
      apply(0, 0, 0, 0, 0);                      // R5 Fetch -> Exec
      apply(0, 0, 0, 1, 1);                      // R6 Exec -> Interrupt
      apply(0, 1, 1, 1, 1);                      // R9 run ignored in Interrupt
      apply(0, 0, 0, 1, 1);                      // R10 Interrupt end -> Fetch
      apply(0, 0, 0, 0, 1);                      // R5
      apply(0, 0, 0, 1, 1);                      // R6
      apply(0, 0, 0, 0, 0);                      // R8
      apply(1, 0, 1, 0, 0);                      // R1 reset mid-run
      for (int i = 0; i < 4000; i++)
         apply(($urandom % 200) == 0, ($urandom % 8) == 0, ($urandom % 4) != 0,
               $urandom % 2, $urandom % 2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: status=%b step=%0d expected run to complete", status, step);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule